// File: doc/BRIEF.md
# Flash power-state sequencing controller

This block decides which operating state an embedded flash array is in. It works from the chip's encoded system mode and from a subclock full-power enable bit. For each state it drives the two flash supply-rail enables, the read and write permissions, a ready flag, and a gate that blocks the flash control registers. The block also holds the six flash control registers that the gate protects. The enable bit is bit 0 of register 5.

When the flash comes back from a reduced-power state (partial power or standby) to a full-power state, the block inserts a supply-settle wait and holds ready low for its length. The wait length is chosen by a 3-bit setting: setting s gives WAIT_BASE << s system clock cycles. A setting that gives less than 20 µs at the configured clock frequency still runs, but it raises an error flag for the whole wait.

A hardware-standby pin forces the standby state at once, with no clock edge, and returns the enable bit to 0.

Top module: `fpwr_seq_ctrl`

## Requirements
- R1: System modes 0, 1 and 2 (high-speed, medium-speed, sleep) give the full read/write state. Read and write enables are 1, both rails are on, ready is 1 and the register gate is open.
- R2: System modes 3 and 4 (subclock active, subclock sleep) with the enable bit at 1 give full-power read-only. Read enable is 1, write enable is 0, both rails are on, ready is 1 and the gate is open.
- R3: System modes 3 and 4 with the enable bit at 0 give partial power. The main rail (pwr_main) is off, the keep rail (pwr_keep) is on, read enable is 1, write enable is 0, ready is 0 and the gate is closed.
- R4: System modes 5, 6 and 7 (watch, software standby, hardware standby) give standby. Both rails are off, read and write are disabled, ready is 0 and the gate is closed. Reset also enters standby.
- R5: On any move from partial power or standby to a full-power state, the block first spends exactly WAIT_BASE << wait_sel cycles settling, counted from the first clock edge that samples the new mode. During the wait both rails are on, read and write are off, ready is 0 and the gate is closed. The target state follows on the next cycle.
- R6: wait_err is 1 throughout any settle wait whose length is below CLK_MHZ × 20 cycles, and 0 at all other times.
- R7: While the gate is closed, register reads return 0 and register writes are discarded.
- R8: When the sampled mode calls for a lower-power state, read and write enables drop in that same cycle. The rails change only at the next clock edge.
- R9: During a settle wait, a mode change whose target still needs full power restarts the full wait. A change whose target is partial power or standby cancels the wait and moves straight to that state at the next edge.
- R10: Driving hw_stby_n low forces standby outputs with no clock edge and clears the enable bit (register 5 bit 0) to 0.
- R11: With the gate open, a register write (reg_req=1, reg_we=1) to addresses 0 to 5 takes effect at the clock edge. A read (reg_req=1, reg_we=0) returns the stored value in the same cycle. Addresses 6 and 7 read as 0, and all registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby_n | input | 1 | Hardware standby override, active low, asynchronous |
| sys_mode | input | 3 | Encoded system operating mode (0 to 7) |
| wait_sel | input | SEL_W | Settle-wait length selector |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (combinational) |
| rd_en | output | 1 | Flash read permitted |
| wr_en | output | 1 | Flash write permitted |
| pwr_main | output | 1 | Main supply rail enable |
| pwr_keep | output | 1 | Keep-alive supply rail enable |
| ready | output | 1 | Flash at full power and settled |
| reg_block | output | 1 | Control register access blocked |
| wait_err | output | 1 | Current settle wait is shorter than the minimum |

## Verification
Read data and the read/write enables are combinational, so they are due in the same cycle as the stimulus. The rails, ready and the gate follow the state register and change one edge after the mode is sampled. A return to full power keeps ready low for exactly the selected count and raises it on the next cycle. The scoreboard tags each expected item with the cycle number in which it is due. The monitor compares the items at the falling clock edge and counts any item it reaches late as a failure. For each settle wait, the bench checks the first and the last settling cycles and then the first ready cycle, so a wait that is one cycle short or long is caught.

// File: rtl/fpwr_pkg.sv
`timescale 1ns/1ps
package fpwr_pkg;

   typedef enum logic [2:0] {
      SM_HIGH   = 3'd0,
      SM_MED    = 3'd1,
      SM_SLEEP  = 3'd2,
      SM_SUBACT = 3'd3,
      SM_SUBSLP = 3'd4,
      SM_WATCH  = 3'd5,
      SM_SWSTBY = 3'd6,
      SM_HWSTBY = 3'd7
   } sysmode_e;

   typedef enum logic [2:0] {
      FS_STBY   = 3'd0,
      FS_PDN    = 3'd1,
      FS_RO     = 3'd2,
      FS_RW     = 3'd3,
      FS_SETTLE = 3'd4
   } fstate_e;

   function automatic logic fs_full(input fstate_e s);
      return (s == FS_RW) || (s == FS_RO);
   endfunction

   function automatic logic fs_readable(input fstate_e s);
      return (s == FS_RW) || (s == FS_RO) || (s == FS_PDN);
   endfunction

endpackage

// File: rtl/fpwr_tgt_dec.sv
`timescale 1ns/1ps
module fpwr_tgt_dec
   import fpwr_pkg::*;
(
   input  logic [2:0] mode_i,
   input  logic       fullpwr_bit_i,
   output fstate_e    tgt_o
);

   always_comb begin
      case (sysmode_e'(mode_i))
         SM_HIGH, SM_MED, SM_SLEEP: tgt_o = FS_RW;
         SM_SUBACT, SM_SUBSLP:      tgt_o = fullpwr_bit_i ? FS_RO : FS_PDN;
         default:                   tgt_o = FS_STBY;
      endcase
   end

endmodule

// File: rtl/fpwr_settle_tmr.sv
`timescale 1ns/1ps
module fpwr_settle_tmr #(
   parameter int SEL_W     = 3,
   parameter int WAIT_BASE = 64,
   parameter int CLK_MHZ   = 125,
   parameter int MIN_US    = 20
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             load_i,
   input  logic             run_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             zero_o,
   output logic             short_o
);

   localparam int CNT_W   = $clog2(WAIT_BASE) + (1 << SEL_W);
   localparam int MIN_CYC = CLK_MHZ * MIN_US;

   logic [CNT_W-1:0] cnt_q;
   logic             short_q;

   function automatic logic [CNT_W-1:0] preset(input logic [SEL_W-1:0] s);
      return CNT_W'(WAIT_BASE) << s;
   endfunction

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q   <= '0;
         short_q <= 1'b0;
      end else if (load_i) begin
         cnt_q   <= preset(sel_i) - CNT_W'(1);
         short_q <= (32'(preset(sel_i)) < 32'(MIN_CYC));
      end else if (run_i && (cnt_q != '0)) begin
         cnt_q   <= cnt_q - CNT_W'(1);
      end
   end

   assign zero_o  = (cnt_q == '0);
   assign short_o = short_q;

endmodule

// File: rtl/fpwr_regbank.sv
`timescale 1ns/1ps
module fpwr_regbank #(
   parameter int NREG    = 6,
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 3,
   parameter int PWR_IDX = 5,
   parameter int PWR_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arst_n,
   input  logic              block_i,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              fullpwr_bit_o
);

   logic [DATA_W-1:0] regs [NREG];
   logic              wr_ok;

   assign wr_ok = req_i && we_i && !block_i;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic              sel;
      logic [DATA_W-1:0] q;
      assign sel = wr_ok && (addr_i == ADDR_W'(i));
      if (i == PWR_IDX) begin : g_pwr
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)  q <= '0;
            else if (sel) q <= wdata_i;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (sel) q <= wdata_i;
         end
      end
      assign regs[i] = q;
   end

   always_comb begin
      rdata_o = '0;
      if (req_i && !we_i && !block_i) begin
         for (int i = 0; i < NREG; i++) begin
            if (addr_i == ADDR_W'(i)) rdata_o = regs[i];
         end
      end
   end

   assign fullpwr_bit_o = regs[PWR_IDX][PWR_BIT];

endmodule

// File: rtl/fpwr_seq_ctrl.sv
`timescale 1ns/1ps
module fpwr_seq_ctrl
   import fpwr_pkg::*;
#(
   parameter int SEL_W     = 3,
   parameter int WAIT_BASE = 64,
   parameter int CLK_MHZ   = 125,
   parameter int MIN_US    = 20,
   parameter int NREG      = 6,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int PWR_IDX   = 5,
   parameter int PWR_BIT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby_n,
   input  logic [2:0]        sys_mode,
   input  logic [SEL_W-1:0]  wait_sel,
   input  logic              reg_req,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              rd_en,
   output logic              wr_en,
   output logic              pwr_main,
   output logic              pwr_keep,
   output logic              ready,
   output logic              reg_block,
   output logic              wait_err
);

   localparam int MIN_CYC = CLK_MHZ * MIN_US;
   localparam int MAX_CYC = WAIT_BASE << ((1 << SEL_W) - 1);

   if (NREG > (1 << ADDR_W)) begin : g_chk_addr
      $error("fpwr_seq_ctrl: NREG does not fit the address width");
   end
   if (PWR_IDX >= NREG) begin : g_chk_idx
      $error("fpwr_seq_ctrl: power register index out of range");
   end
   if (PWR_BIT >= DATA_W) begin : g_chk_bit
      $error("fpwr_seq_ctrl: enable bit position out of range");
   end
   if (MAX_CYC < MIN_CYC) begin : g_chk_wait
      $error("fpwr_seq_ctrl: no wait setting reaches the minimum settle time");
   end

   logic       arst_n;
   fstate_e    state_q, settle_tgt_q, tgt;
   logic [2:0] mode_q;
   logic       fullpwr_bit, tmr_zero, tmr_short;
   logic       restart, tmr_load, tmr_run;

   assign arst_n = rst_n & hw_stby_n;

   fpwr_tgt_dec u_dec (
      .mode_i        (sys_mode),
      .fullpwr_bit_i (fullpwr_bit),
      .tgt_o         (tgt)
   );

   assign restart  = (sys_mode != mode_q) || (tgt != settle_tgt_q);
   assign tmr_run  = (state_q == FS_SETTLE);
   assign tmr_load = fs_full(tgt) &&
                     (((state_q == FS_PDN) || (state_q == FS_STBY)) ||
                      ((state_q == FS_SETTLE) && restart));

   fpwr_settle_tmr #(
      .SEL_W     (SEL_W),
      .WAIT_BASE (WAIT_BASE),
      .CLK_MHZ   (CLK_MHZ),
      .MIN_US    (MIN_US)
   ) u_tmr (
      .clk     (clk),
      .arst_n  (arst_n),
      .load_i  (tmr_load),
      .run_i   (tmr_run),
      .sel_i   (wait_sel),
      .zero_o  (tmr_zero),
      .short_o (tmr_short)
   );

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q      <= FS_STBY;
         settle_tgt_q <= FS_RW;
         mode_q       <= '0;
      end else begin
         mode_q <= sys_mode;
         case (state_q)
            FS_RW, FS_RO: state_q <= tgt;
            FS_PDN, FS_STBY: begin
               if (fs_full(tgt)) begin
                  state_q      <= FS_SETTLE;
                  settle_tgt_q <= tgt;
               end else begin
                  state_q <= tgt;
               end
            end
            FS_SETTLE: begin
               if (!fs_full(tgt))  state_q      <= tgt;
               else if (restart)   settle_tgt_q <= tgt;
               else if (tmr_zero)  state_q      <= settle_tgt_q;
            end
            default: state_q <= FS_STBY;
         endcase
      end
   end

   assign rd_en     = hw_stby_n && fs_readable(state_q) && fs_readable(tgt);
   assign wr_en     = hw_stby_n && (state_q == FS_RW) && (tgt == FS_RW);
   assign pwr_main  = fs_full(state_q) || (state_q == FS_SETTLE);
   assign pwr_keep  = (state_q != FS_STBY);
   assign ready     = fs_full(state_q);
   assign reg_block = !ready;
   assign wait_err  = (state_q == FS_SETTLE) && tmr_short;

   fpwr_regbank #(
      .NREG    (NREG),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .PWR_IDX (PWR_IDX),
      .PWR_BIT (PWR_BIT)
   ) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .arst_n        (arst_n),
      .block_i       (reg_block),
      .req_i         (reg_req),
      .we_i          (reg_we),
      .addr_i        (reg_addr),
      .wdata_i       (reg_wdata),
      .rdata_o       (reg_rdata),
      .fullpwr_bit_o (fullpwr_bit)
   );

endmodule

// File: rtl/fpwr_seq_chk.sv
`timescale 1ns/1ps
module fpwr_seq_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hw_stby_n,
   input logic [2:0]        sys_mode,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              rd_en,
   input logic              wr_en,
   input logic              pwr_main,
   input logic              pwr_keep,
   input logic              ready,
   input logic              reg_block,
   input logic              wait_err
);

   a_r8_low_mode_gates: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_mode >= 3'd5) |-> (!rd_en && !wr_en));

   a_r4_standby_rails_off: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_mode >= 3'd5) |=> (!pwr_main && !pwr_keep && !ready));

   a_r1_write_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ready && pwr_main));

   a_r7_blocked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_block |-> (reg_rdata == '0));

   a_r5_ready_after_power: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(pwr_main));

   a_r6_err_only_settling: assert property (@(posedge clk) disable iff (!rst_n)
      wait_err |-> (!ready && pwr_main && pwr_keep && !rd_en));

   a_r10_hw_override: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_stby_n |-> (!pwr_main && !pwr_keep && !rd_en && !wr_en));

   a_r3_partial_rails: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_keep && !pwr_main) |-> (!ready && !wr_en && reg_block));

endmodule

bind fpwr_seq_ctrl fpwr_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hw_stby_n (hw_stby_n),
   .sys_mode  (sys_mode),
   .reg_rdata (reg_rdata),
   .rd_en     (rd_en),
   .wr_en     (wr_en),
   .pwr_main  (pwr_main),
   .pwr_keep  (pwr_keep),
   .ready     (ready),
   .reg_block (reg_block),
   .wait_err  (wait_err)
);

// File: tb/fpwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module fpwr_seq_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0, hw_stby_n = 1'b1;
   logic [2:0] sys_mode = 3'd0, wait_sel = 3'd0;
   logic       reg_req = 1'b0, reg_we = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'd0, reg_rdata;
   logic       rd_en, wr_en, pwr_main, pwr_keep, ready, reg_block, wait_err;

   always #4 clk = ~clk;

   fpwr_seq_ctrl uut (.*);

   // status vector {rd,wr,main,keep,ready,block,err}
   localparam logic [6:0] V_SB   = 7'b0000010;
   localparam logic [6:0] V_PD   = 7'b1001010;
   localparam logic [6:0] V_RW   = 7'b1111100;
   localparam logic [6:0] V_RO   = 7'b1011100;
   localparam logic [6:0] V_SET  = 7'b0011010;
   localparam logic [6:0] V_DROP = 7'b0011100;

   typedef struct {
      int         due;
      bit         is_data;
      logic [7:0] val;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0, checks = 0, fails = 0;
   bit   done = 1'b0;
   logic [6:0] st_now;

   assign st_now = {rd_en, wr_en, pwr_main, pwr_keep, ready, reg_block, wait_err};

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      exp_t       e;
      logic [7:0] act;
      while (q.size() > 0 && q[0].due <= cyc) begin
         e = q.pop_front();
         act = e.is_data ? reg_rdata : {1'b0, st_now};
         checks++;
         if (e.due < cyc || act !== e.val) begin
            fails++;
            $display("FAIL %s cycle %0d: actual=%b expected=%b", e.tag, e.due, act, e.val);
         end
      end
   end

   function automatic void push_st(int due, logic [6:0] v, string tag);
      q.push_back('{due, 1'b0, {1'b0, v}, tag});
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wait_until(int t);
      while (cyc < t) tick();
   endtask

   // inputs already changed in this cycle; wait begins at the next edge
   task automatic run_settle(int n, logic err, logic [6:0] fin, string tag);
      int c;
      c = cyc;
      push_st(c + 1, V_SET | {6'd0, err}, tag);
      push_st(c + n, V_SET | {6'd0, err}, tag);
      push_st(c + n + 1, fin, tag);
      wait_until(c + n + 2);
   endtask

   task automatic wr_reg(logic [2:0] a, logic [7:0] d);
      reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_req = 1'b0; reg_we = 1'b0;
   endtask

   task automatic rd_reg(logic [2:0] a, logic [7:0] exp, string tag);
      reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
      q.push_back('{cyc, 1'b1, exp, tag});
      tick();
      reg_req = 1'b0;
   endtask

   task automatic set_mode(logic [2:0] m, logic [6:0] now_v, logic [6:0] next_v, string tag);
      int c;
      sys_mode = m;
      c = cyc;
      push_st(c, now_v, tag);
      push_st(c + 1, next_v, tag);
      wait_until(c + 2);
   endtask

   initial begin
      int c;
      repeat (3) tick();
      push_st(cyc, V_SB, "R4 reset state");
      tick();
      rst_n = 1'b1;
      run_settle(64, 1'b1, V_RW, "R5 R6 R1 power-up settle short");

      wr_reg(3'd2, 8'hA5);
      rd_reg(3'd2, 8'hA5, "R11 readback");
      rd_reg(3'd6, 8'h00, "R11 unmapped address");
      rd_reg(3'd0, 8'h00, "R11 reset value");
      wr_reg(3'd5, 8'h01);
      rd_reg(3'd5, 8'h01, "R11 enable bit");

      set_mode(3'd3, V_RO, V_RO, "R2 R8 subclock full power");

      wr_reg(3'd5, 8'h00);
      push_st(cyc, V_RO, "R8 rails hold for one edge");
      push_st(cyc + 1, V_PD, "R3 partial power");
      wait_until(cyc + 2);

      wr_reg(3'd2, 8'h3C);
      rd_reg(3'd2, 8'h00, "R7 blocked read");

      sys_mode = 3'd0; wait_sel = 3'd6;
      run_settle(4096, 1'b0, V_RW, "R5 R6 long settle");
      rd_reg(3'd2, 8'hA5, "R7 blocked write discarded");

      set_mode(3'd5, V_DROP, V_SB, "R8 R4 watch");
      set_mode(3'd7, V_SB, V_SB, "R4 hardware standby code");

      sys_mode = 3'd0; wait_sel = 3'd0;
      c = cyc;
      push_st(c + 1, V_SET | 7'd1, "R9 first wait");
      wait_until(c + 10);
      sys_mode = 3'd1;
      run_settle(64, 1'b1, V_RW, "R9 restart");

      set_mode(3'd6, V_DROP, V_SB, "R4 software standby");
      sys_mode = 3'd0;
      c = cyc;
      wait_until(c + 5);
      sys_mode = 3'd4;
      push_st(cyc, V_SET | 7'd1, "R9 before cancel");
      push_st(cyc + 1, V_PD, "R9 cancel to partial");
      wait_until(cyc + 2);

      sys_mode = 3'd0;
      run_settle(64, 1'b1, V_RW, "R5 exit partial");
      wr_reg(3'd5, 8'h01);
      set_mode(3'd3, V_RO, V_RO, "R2 before override");
      hw_stby_n = 1'b0;
      push_st(cyc, V_SB, "R10 async override");
      tick();
      push_st(cyc, V_SB, "R10 held");
      tick();
      hw_stby_n = 1'b1;
      push_st(cyc, V_SB, "R10 release");
      push_st(cyc + 1, V_PD, "R10 enable bit cleared");
      wait_until(cyc + 3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule